// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides where each of the two ALU operands of a five-stage in-order pipeline comes from during the execute stage. It compares the two source register indices held for the instruction now in execute against the destination indices of the two older instructions still in flight. One of those older instructions sits in the memory stage and the other in the write-back stage. For each operand it produces a 2-bit select code that steers the operand multiplexer. The code picks the register-file value, the memory-stage result or the write-back-stage result.

The logic is purely combinational. A destination index of zero is never bypassed, because register zero always reads as zero. When both older instructions write the register an operand needs, the memory-stage result is chosen, because it is the more recent value. The two operands are resolved independently of each other.

Top module: `operand_bypass_select`

## Requirements
- R1: For each operand, the select code is 2'b10 whenever the memory-stage write flag is 1, its destination index is nonzero, and that index equals the operand's source index.
- R2: For each operand, the select code is 2'b01 when the write-back-stage write flag is 1, its destination index is nonzero and equals the operand's source index, and the condition of R1 does not hold for that operand.
- R3: When the memory-stage and write-back-stage conditions both hold for the same operand, the code is 2'b10, so the newer result wins.
- R4: A destination index of 0 never causes a nonzero code, from either stage, even when a source index is also 0.
- R5: The code is 2'b00, meaning register file, when neither stage condition holds, including any case where the matching stage's write flag is 0.
- R6: Operand A uses source index `ex_rs1_idx` and operand B uses `ex_rs2_idx`. The two codes are computed independently, so both may be nonzero in the same cycle, from the same stage or from different stages.
- R7: The code 2'b11 is never produced on either select output.
- R8: The outputs depend only on the present inputs; no clock or stored state is involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs1_idx | input | IDX_W | First source register index of the instruction in execute |
| ex_rs2_idx | input | IDX_W | Second source register index of the instruction in execute |
| mem_wr_en | input | 1 | Memory-stage instruction will write a register |
| mem_dst_idx | input | IDX_W | Memory-stage destination register index |
| wb_wr_en | input | 1 | Write-back-stage instruction will write a register |
| wb_dst_idx | input | IDX_W | Write-back-stage destination register index |
| fwd_sel_a | output | 2 | Operand A source: 00 register file, 01 write-back, 10 memory |
| fwd_sel_b | output | 2 | Operand B source: 00 register file, 01 write-back, 10 memory |

## Verification
The assertions assume the inputs are settled, two-state values whenever the combinational process evaluates. They make no assumption about how indices relate between stages, so any pairing of equal or unequal indices is legal. The stimulus holds every input stable across a whole clock period. It draws the indices from a small set that includes zero, the top index and two middle values, so matches, mismatches and zero destinations occur often. Every write-flag and index combination over that set is applied, followed by random vectors over the full index range.

// File: rtl/operand_bypass_select.sv
module operand_bypass_select #(
  parameter int IDX_W = 5
) (
  input  logic [IDX_W-1:0] ex_rs1_idx,
  input  logic [IDX_W-1:0] ex_rs2_idx,
  input  logic             mem_wr_en,
  input  logic [IDX_W-1:0] mem_dst_idx,
  input  logic             wb_wr_en,
  input  logic [IDX_W-1:0] wb_dst_idx,
  output logic [1:0]       fwd_sel_a,
  output logic [1:0]       fwd_sel_b
);

  localparam int         NSRC    = 2;
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_WB  = 2'b01;
  localparam logic [1:0] SEL_MEM = 2'b10;

  logic [IDX_W-1:0] src [NSRC];
  logic [1:0]       sel [NSRC];

  assign src[0] = ex_rs1_idx;
  assign src[1] = ex_rs2_idx;

  wire mem_live = mem_wr_en && (mem_dst_idx != '0);
  wire wb_live  = wb_wr_en  && (wb_dst_idx  != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    wire mem_hit = mem_live && (mem_dst_idx == src[g]);
    wire wb_hit  = wb_live  && (wb_dst_idx  == src[g]);
    assign sel[g] = mem_hit ? SEL_MEM :
                    wb_hit  ? SEL_WB  : SEL_RF;
  end

  assign fwd_sel_a = sel[0];
  assign fwd_sel_b = sel[1];

  always_comb begin
    AST_NO_CODE3_A: assert (fwd_sel_a != 2'b11); // R7
    AST_NO_CODE3_B: assert (fwd_sel_b != 2'b11); // R7
    AST_MEM_SRC_A: assert (fwd_sel_a != SEL_MEM || (mem_wr_en && mem_dst_idx == ex_rs1_idx)); // R1
    AST_WB_SRC_A: assert (fwd_sel_a != SEL_WB || (wb_wr_en && wb_dst_idx == ex_rs1_idx)); // R2
    AST_WB_SRC_B: assert (fwd_sel_b != SEL_WB || (wb_wr_en && wb_dst_idx == ex_rs2_idx)); // R6
    AST_NEWEST_A: assert (!(mem_wr_en && mem_dst_idx != '0 && mem_dst_idx == ex_rs1_idx) || fwd_sel_a == SEL_MEM); // R3
    AST_ZERO_A: assert (ex_rs1_idx != '0 || fwd_sel_a == SEL_RF); // R4
    AST_ZERO_B: assert (ex_rs2_idx != '0 || fwd_sel_b == SEL_RF); // R4
    AST_IDLE_A: assert (mem_wr_en || wb_wr_en || fwd_sel_a == SEL_RF); // R5
  end

endmodule

// File: tb/operand_bypass_select_bench.sv
module operand_bypass_select_bench;

  localparam int IDX_W = 5;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [IDX_W-1:0] rs1, rs2, md, wd;
  logic             mw, ww;
  logic [1:0]       sa, sb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  operand_bypass_select #(.IDX_W(IDX_W)) u_operand_bypass_select (
    .ex_rs1_idx(rs1), .ex_rs2_idx(rs2),
    .mem_wr_en(mw), .mem_dst_idx(md),
    .wb_wr_en(ww), .wb_dst_idx(wd),
    .fwd_sel_a(sa), .fwd_sel_b(sb)
  );

  function automatic int ref_code(int src, bit mwe, int mdst, bit wwe, int wdst);
    if (mwe && mdst != 0 && mdst == src) return 2;
    if (wwe && wdst != 0 && wdst == src) return 1;
    return 0;
  endfunction

  function automatic string tag_of(int code, int src, bit is_b);
    if (is_b) return "R6";
    if (code == 2) return "R1/R3";
    if (code == 1) return "R2";
    if (src == 0) return "R4";
    return "R5";
  endfunction

  task automatic compare(string note);
    int ea, eb;
    ea = ref_code(int'(rs1), mw, int'(md), ww, int'(wd));
    eb = ref_code(int'(rs2), mw, int'(md), ww, int'(wd));
    checks += 2;
    if (int'(sa) != ea) begin
      errors++;
      $display("FAIL %s %s operand A: actual %0d expected %0d", tag_of(ea, int'(rs1), 0), note, sa, ea);
    end
    if (int'(sb) != eb) begin
      errors++;
      $display("FAIL %s %s operand B: actual %0d expected %0d", tag_of(eb, int'(rs2), 1), note, sb, eb);
    end
    checks++;
    if (sa == 2'b11 || sb == 2'b11) begin
      errors++;
      $display("FAIL R7 %s: actual %0d/%0d expected no code 3", note, sa, sb);
    end
  endtask

  task automatic apply(logic [IDX_W-1:0] a, logic [IDX_W-1:0] b, logic me,
                       logic [IDX_W-1:0] mdst, logic we, logic [IDX_W-1:0] wdst, string note);
    @(posedge clk);
    #1;
    rs1 = a; rs2 = b; mw = me; md = mdst; ww = we; wd = wdst;
    #1;
    compare({note, " R8 settle"});
    @(negedge clk);
    compare(note);
  endtask

  initial begin
    int pick [4] = '{0, 1, 17, 31};
    rs1 = '0; rs2 = '0; mw = 1'b0; md = '0; ww = 1'b0; wd = '0;
    @(negedge clk);
    checks++;
    if (sa != 2'b00 || sb != 2'b00) begin
      errors++;
      $display("FAIL R5 idle inputs: actual %0d/%0d expected 0/0", sa, sb);
    end
    // directed corner cases
    apply(5'd3, 5'd4, 1'b1, 5'd3, 1'b1, 5'd3, "R3 both stages match A");
    apply(5'd0, 5'd0, 1'b1, 5'd0, 1'b1, 5'd0, "R4 zero dst and src");
    apply(5'd7, 5'd9, 1'b1, 5'd7, 1'b1, 5'd9, "R6 A from mem B from wb");
    apply(5'd7, 5'd7, 1'b0, 5'd7, 1'b1, 5'd7, "R2 both from wb");
    apply(5'd7, 5'd7, 1'b1, 5'd7, 1'b0, 5'd0, "R1 both from mem");
    apply(5'd12, 5'd5, 1'b0, 5'd12, 1'b0, 5'd5, "R5 flags low");
    apply(5'd8, 5'd8, 1'b1, 5'd0, 1'b1, 5'd8, "R4 mem dst zero lets wb");
    // sweep over a small index set
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++)
        for (int m = 0; m < 4; m++)
          for (int w = 0; w < 4; w++)
            for (int f = 0; f < 4; f++)
              apply(IDX_W'(pick[a]), IDX_W'(pick[b]), f[0], IDX_W'(pick[m]),
                    f[1], IDX_W'(pick[w]), "sweep");
    for (int i = 0; i < 3000; i++)
      apply(IDX_W'($urandom), IDX_W'($urandom), 1'($urandom), IDX_W'($urandom),
            1'($urandom), IDX_W'($urandom), "random");
    done = 1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule